// File: doc/BRIEF.md
# Binary and Packed-Decimal Converter

This block translates between a 16-bit unsigned binary number and four decimal digits packed four bits each. A single unit covers both directions. The caller picks a direction, loads the operand and raises `start` for one cycle. The block then runs an iterative datapath that handles one decimal digit per step. When the result is ready it pulses `done` for one cycle. The result and its out-of-range flag then stay on the outputs until the next conversion finishes.

In the binary-to-decimal direction, the block divides the operand by ten four times. Each division is a restoring shift-subtract that takes sixteen cycles. The remainder of each division becomes the next digit, and the quotient feeds the following division. In the decimal-to-binary direction, the block walks the digits from the most significant one down. It multiplies the running total by ten and adds the next digit, taking one cycle per digit. Operands outside the decimal range still produce a result from the same arithmetic, and that result is flagged.

Top module: `bcd_codec`

## Requirements
- R1: With `to_bcd`=1, `dout` holds the four decimal digits of `din`. The least significant digit is in bits 3:0 and the most significant in bits 15:12. Each digit is the remainder of dividing the previous quotient by ten.
- R2: With `to_bcd`=0, `din` is read as four 4-bit digits with the most significant in bits 15:12. `dout` is the Horner sum acc = acc*10 + digit, taken from the top digit down, with every step truncated to 16 bits.
- R3: Binary 0x162E converts to 0x5678, and 0x5678 converts back to 0x162E.
- R4: With `to_bcd`=1, `range_err` is 1 exactly when `din` > 9999. The digits are still produced by four divisions, so 0xFFFF gives 0x5535.
- R5: With `to_bcd`=0, `range_err` is 1 exactly when some nibble of `din` exceeds 9. `dout` is still the truncated Horner sum of the raw nibbles.
- R6: `done` is a one-cycle pulse. Taking the edge that samples `start` as edge 0, `done` is first seen after edge 64 for `to_bcd`=1 and after edge 4 for `to_bcd`=0. `busy` is high in between.
- R7: A `start` raised while `busy` is high is ignored. The running conversion ends with its own result and latency.
- R8: While `rst_n` is low, `busy`, `done`, `dout` and `range_err` are all 0.
- R9: `dout` and `range_err` change only in the cycle where `done` is raised, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when the block is idle |
| to_bcd | input | 1 | 1: binary to decimal digits, 0: decimal digits to binary |
| din | input | 16 | Operand |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| dout | output | 16 | Result, held until the next completion |
| range_err | output | 1 | Operand was outside the decimal range |

## Verification
The bench targets the following corner cases:
- **The edges of the decimal range.** It checks 9999, 10000 and 0xFFFF, where a bad comparison constant would set the flag one value off.
- **Bad nibbles.** These include 0xA, 0xF and bad nibbles in the top position. A design that truncates differently, or skips the top nibble in the check, would return a wrong sum or a missing flag.
- **Every valid decimal operand and a wide random sample of binary operands.** This catches digit-order swaps and remainder off-by-ones.
- **Timing.** It measures the exact latency of both directions, and it fires `start` in the middle of a conversion. A design that restarts on that pulse would return the second operand's result or the wrong latency.

// File: rtl/bcd_codec.sv
module bcd_codec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        to_bcd,
  input  logic [15:0] din,
  output logic        busy,
  output logic        done,
  output logic [15:0] dout,
  output logic        range_err
);
  localparam int W      = 16;
  localparam int DIGITS = W / 4;
  localparam int MAXDEC = 9999;

  logic          run, mode, err;
  logic [W-1:0]  q, w, src;
  logic [3:0]    r;
  logic [3:0]    bit_cnt;
  logic [1:0]    dig_cnt;

  logic [4:0]    r_sh;
  logic          ge;
  logic [3:0]    r_nx;
  logic [W-1:0]  q_nx, w_dig, mac;

  function automatic logic bad_digit(input logic [W-1:0] v);
    logic b;
    b = 1'b0;
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) b = 1'b1;
    return b;
  endfunction

  assign r_sh  = {r, q[W-1]};
  assign ge    = r_sh >= 5'd10;
  assign r_nx  = ge ? 4'(r_sh - 5'd10) : r_sh[3:0];
  assign q_nx  = {q[W-2:0], ge};
  assign w_dig = {r_nx, w[W-1:4]};
  assign mac   = 16'(w * 16'd10) + {12'd0, src[W-1:W-4]};
  assign busy  = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; mode <= 1'b0; err <= 1'b0;
      q <= '0; w <= '0; src <= '0; r <= '0;
      bit_cnt <= '0; dig_cnt <= '0;
      done <= 1'b0; dout <= '0; range_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (start) begin
          run     <= 1'b1;
          mode    <= to_bcd;
          q       <= din;
          src     <= din;
          r       <= '0;
          w       <= '0;
          bit_cnt <= '0;
          dig_cnt <= '0;
          err     <= to_bcd ? (din > 16'(MAXDEC)) : bad_digit(din);
        end
      end else if (mode) begin
        q       <= q_nx;
        r       <= r_nx;
        bit_cnt <= bit_cnt + 4'd1;
        if (bit_cnt == 4'd15) begin
          r       <= '0;
          w       <= w_dig;
          dig_cnt <= dig_cnt + 2'd1;
          if (dig_cnt == 2'(DIGITS - 1)) begin
            run       <= 1'b0;
            done      <= 1'b1;
            dout      <= w_dig;
            range_err <= err;
          end
        end
      end else begin
        w       <= mac;
        src     <= {src[W-5:0], 4'd0};
        dig_cnt <= dig_cnt + 2'd1;
        if (dig_cnt == 2'(DIGITS - 1)) begin
          run       <= 1'b0;
          done      <= 1'b1;
          dout      <= mac;
          range_err <= err;
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(run) && !run);
  // R7
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(dout) && $stable(range_err));
  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (run && mode) |-> r < 4'd10);
endmodule

// File: tb/sim_bcd_codec.sv
module sim_bcd_codec;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, to_bcd = 1'b0;
  logic [15:0] din = '0;
  logic busy, done, range_err;
  logic [15:0] dout;
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_codec u0 (.clk(clk), .rst_n(rst_n), .start(start), .to_bcd(to_bcd),
                .din(din), .busy(busy), .done(done), .dout(dout), .range_err(range_err));

  function automatic logic [15:0] ref_b2d(input logic [15:0] v);
    logic [15:0] x, res;
    x = v; res = '0;
    for (int i = 0; i < 4; i++) begin
      res[4*i +: 4] = 4'(x % 16'd10);
      x = x / 16'd10;
    end
    return res;
  endfunction

  function automatic logic [15:0] ref_d2b(input logic [15:0] v);
    logic [15:0] acc;
    acc = '0;
    for (int i = 3; i >= 0; i--) acc = 16'(acc * 16'd10) + {12'd0, v[4*i +: 4]};
    return acc;
  endfunction

  function automatic logic ref_bad(input logic [15:0] v);
    logic b;
    b = 1'b0;
    for (int i = 0; i < 4; i++) if (v[4*i +: 4] > 4'd9) b = 1'b1;
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic dir, input logic [15:0] v, input string req,
                         input bit check_lat, input bit poke);
    int lat;
    @(negedge clk);
    start = 1'b1; to_bcd = dir; din = v;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 10) begin
        start = 1'b1; to_bcd = ~dir; din = 16'h1234;
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(req, dout, dir ? ref_b2d(v) : ref_d2b(v));
    chk(req, range_err, dir ? (v > 16'd9999) : ref_bad(v));
    if (check_lat) chk("R6 latency", lat, dir ? 64 : 4);
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R8 busy", busy, 0); chk("R8 done", done, 0);
    chk("R8 dout", dout, 0); chk("R8 err", range_err, 0);
    rst_n = 1'b1;

    convert(1'b1, 16'h162E, "R3", 1'b1, 1'b0);
    chk("R3 b2d", dout, 16'h5678);
    @(negedge clk); chk("R6 pulse", done, 0); chk("R6 idle", busy, 0);
    convert(1'b0, 16'h5678, "R3", 1'b1, 1'b0);
    chk("R3 d2b", dout, 16'h162E);

    convert(1'b1, 16'd9999,  "R4 top", 1'b0, 1'b0);
    convert(1'b1, 16'd10000, "R4 over", 1'b0, 1'b0);
    convert(1'b1, 16'hFFFF,  "R4 max", 1'b0, 1'b0);
    chk("R4 ffff", dout, 16'h5535);
    convert(1'b1, 16'd0, "R1 zero", 1'b0, 1'b0);
    convert(1'b0, 16'hFFFF, "R5 all", 1'b0, 1'b0);
    convert(1'b0, 16'hA000, "R5 top", 1'b0, 1'b0);
    convert(1'b0, 16'h000A, "R5 low", 1'b0, 1'b0);
    convert(1'b0, 16'h0990, "R2 mid", 1'b0, 1'b0);

    convert(1'b1, 16'h162E, "R7 ignore", 1'b1, 1'b1);
    chk("R7 result", dout, 16'h5678);

    held = dout;
    repeat (20) @(negedge clk);
    chk("R9 hold", dout, held); chk("R9 err", range_err, 0);

    for (int i = 0; i < 10000; i++)
      convert(1'b0, ref_b2d(16'(i)), "R2", 1'b0, 1'b0);
    for (int i = 0; i < 300; i++)
      convert(1'b0, 16'($urandom), "R5", 1'b0, 1'b0);
    for (int i = 0; i < 1000; i++)
      convert(1'b1, 16'($urandom % 10000), "R1", 1'b0, 1'b0);
    for (int i = 0; i < 100; i++)
      convert(1'b1, 16'($urandom), "R4", 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule